// File: doc/BRIEF.md
# Fractional-Rate Audio Sample Decimator

This block takes one signed audio sample per source clock cycle and produces output samples at a lower, non-integer rate. The rate is set by a ratio input: the number of source cycles per output sample, unsigned, with 10 fractional bits. A phase remainder with the same 10 fractional bits is kept from one output interval to the next. Because of this, a fractional ratio such as 22.3 gives intervals of 22 or 23 cycles, and in the long run their average is exactly the ratio.

Two selection modes exist. In nearest mode the phase carries a half-cycle bias, and the output is the source sample that ends the interval. In blend mode the output is a linear mix of the last two source samples. The weight of the mix is the 10-bit fractional phase. In both modes the result is clamped to a signed output width set by a parameter. The output side uses valid/ready. While an output waits, no source sample is taken, so no source cycles are lost.

Top module: `decim_rate`

## Requirements
- R1: After reset, out_valid is low, in_ready is high, the phase remainder is zero and the remembered previous sample is zero.
- R2: With mode_sel = 0 (nearest), each interval starts with a sum s = remainder + ratio + 512. The interval lasts s >> 10 accepted samples, and its output is the accepted sample that ends it.
- R3: In nearest mode the remainder kept for the next interval is (s mod 1024) - 512.
- R4: With mode_sel = 1 (blend), each interval starts with s = remainder + ratio. It lasts s >> 10 accepted samples, and the kept remainder is s mod 1024.
- R5: In blend mode the output is p + floor(f * (c - p) / 1024). Here c is the sample that ends the interval, p is the previous sample, and f is the remainder just kept. The shift is arithmetic.
- R6: The previous sample p is the sample accepted just before c, even when it belongs to the earlier interval. It is zero if no sample has been accepted since reset.
- R7: out_sample is clamped to the signed OUT_W range, from -2^(OUT_W-1) to 2^(OUT_W-1)-1.
- R8: While out_valid is high and out_ready is low, in_ready is low, and out_valid and out_sample hold their values.
- R9: ratio and mode_sel are sampled only on the first accepted sample of an interval. A change made during an interval takes effect from the next interval.
- R10: A cycle with in_valid low does not advance the phase. A ratio whose integer part is zero gives intervals of one sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0 = nearest, 1 = blend |
| ratio | input | RATIO_W | Source cycles per output, 10 fractional bits |
| in_valid | input | 1 | Source sample present this cycle |
| in_ready | output | 1 | Source sample is taken this cycle |
| in_sample | input | IN_W | Signed source sample |
| out_valid | output | 1 | Output sample held |
| out_ready | input | 1 | Output sample consumed |
| out_sample | output | OUT_W | Signed, clamped output sample |

## Verification
Two events can fall in the same clock edge: a held output is drained, and the source sample that completes the next interval is accepted, which loads the next output into the same register. The bench provokes this with ratios just above one, so that nearly every sample ends an interval, while out_ready toggles pseudo-randomly. It judges the result by matching every drained output, in order, against a model computed arithmetically from the stated phase rules, and by checking at the end that no expected output went missing or appeared twice.

// File: rtl/decim_rate_pkg.sv
package decim_rate_pkg;
  localparam int FRAC_W = 10;
  localparam int HALF   = 1 << (FRAC_W - 1);

  typedef enum logic {
    PICK_NEAREST = 1'b0,
    PICK_BLEND   = 1'b1
  } pick_e;
endpackage

// File: rtl/decim_rst_sync.sv
module decim_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/decim_phase.sv
module decim_phase
  import decim_rate_pkg::*;
#(
  parameter int RATIO_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step,
  input  pick_e                    mode_in,
  input  logic [RATIO_W-1:0]       ratio_in,
  output logic                     fire,
  output logic [FRAC_W-1:0]        blend_frac,
  output pick_e                    mode_eff,
  output logic signed [FRAC_W:0]   off_held
);
  localparam int CNT_W = RATIO_W - FRAC_W + 1;
  localparam int PH_W  = RATIO_W + 2;

  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic signed [FRAC_W:0]  off_q, off_d;
  pick_e                   mode_q, mode_d;

  logic                    starting;
  logic signed [PH_W-1:0]  off_ext, bias, ratio_ext, nxt;
  logic [CNT_W-1:0]        dt, dt_use, cnt_eff;
  logic signed [FRAC_W:0]  kept, off_eff;

  always_comb begin
    starting  = (cnt_q == '0);
    off_ext   = {{(PH_W-FRAC_W-1){off_q[FRAC_W]}}, off_q};
    ratio_ext = $signed({2'b00, ratio_in});
    bias      = (mode_in == PICK_NEAREST) ? PH_W'(HALF) : '0;
    nxt       = ratio_ext + off_ext + bias;
    dt        = CNT_W'(nxt >>> FRAC_W);
    dt_use    = (dt == '0) ? CNT_W'(1) : dt;
    if (mode_in == PICK_NEAREST)
      kept = $signed({1'b0, nxt[FRAC_W-1:0]}) - $signed((FRAC_W+1)'(HALF));
    else
      kept = $signed({1'b0, nxt[FRAC_W-1:0]});

    cnt_eff    = starting ? dt_use  : cnt_q;
    off_eff    = starting ? kept    : off_q;
    mode_eff   = starting ? mode_in : mode_q;
    fire       = step && (cnt_eff == CNT_W'(1));
    blend_frac = FRAC_W'(off_eff);
  end

  always_comb begin
    cnt_d  = cnt_eff - CNT_W'(1);
    off_d  = starting ? kept : off_q;
    mode_d = starting ? mode_in : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      off_q  <= '0;
      mode_q <= PICK_NEAREST;
    end else if (step) begin
      cnt_q  <= cnt_d;
      off_q  <= off_d;
      mode_q <= mode_d;
    end
  end

  assign off_held = off_q;
endmodule

// File: rtl/decim_blend.sv
module decim_blend
  import decim_rate_pkg::*;
#(
  parameter int IN_W = 20
) (
  input  logic signed [IN_W-1:0] prev_s,
  input  logic signed [IN_W-1:0] now_s,
  input  logic [FRAC_W-1:0]      frac,
  input  pick_e                  mode,
  output logic signed [IN_W+1:0] mixed
);
  localparam int EW = IN_W + 2;
  localparam int PW = IN_W + FRAC_W + 2;

  logic signed [IN_W:0]   diff;
  logic signed [PW-1:0]   prod;
  logic signed [EW-1:0]   prev_ext, now_ext, step_part;

  always_comb begin
    diff      = $signed({now_s[IN_W-1], now_s}) - $signed({prev_s[IN_W-1], prev_s});
    prod      = PW'(diff) * PW'($signed({1'b0, frac}));
    step_part = EW'(prod >>> FRAC_W);
    prev_ext  = EW'(prev_s);
    now_ext   = EW'(now_s);
    mixed     = (mode == PICK_BLEND) ? (prev_ext + step_part) : now_ext;
  end
endmodule

// File: rtl/decim_sat.sv
module decim_sat #(
  parameter int EW    = 22,
  parameter int OUT_W = 16
) (
  input  logic signed [EW-1:0]    val,
  output logic signed [OUT_W-1:0] clamped
);
  generate
    if (OUT_W >= EW) begin : g_pass
      assign clamped = OUT_W'(val);
    end else begin : g_clamp
      localparam logic signed [EW-1:0] MAXV = EW'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
      localparam logic signed [EW-1:0] MINV = EW'(-(64'sd1 <<< (OUT_W-1)));
      always_comb begin
        if (val > MAXV)      clamped = OUT_W'(MAXV);
        else if (val < MINV) clamped = OUT_W'(MINV);
        else                 clamped = OUT_W'(val);
      end
    end
  endgenerate
endmodule

// File: rtl/decim_rate.sv
module decim_rate
  import decim_rate_pkg::*;
#(
  parameter int IN_W    = 20,
  parameter int OUT_W   = 16,
  parameter int RATIO_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_sel,
  input  logic [RATIO_W-1:0]      ratio,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  in_sample,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_sample
);
  localparam int EW = IN_W + 2;

  logic                    rst_n_s;
  logic                    step, fire;
  logic [FRAC_W-1:0]       blend_frac;
  pick_e                   mode_eff;
  logic signed [FRAC_W:0]  phase_off;
  logic signed [IN_W-1:0]  last_q;
  logic signed [EW-1:0]    mixed;
  logic signed [OUT_W-1:0] sat_val;

  logic                    vld_q, vld_d;
  logic signed [OUT_W-1:0] data_q, data_d;

  decim_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  assign in_ready = !(vld_q && !out_ready);
  assign step     = in_valid && in_ready;

  decim_phase #(.RATIO_W(RATIO_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .step       (step),
    .mode_in    (pick_e'(mode_sel)),
    .ratio_in   (ratio),
    .fire       (fire),
    .blend_frac (blend_frac),
    .mode_eff   (mode_eff),
    .off_held   (phase_off)
  );

  decim_blend #(.IN_W(IN_W)) u_blend (
    .prev_s (last_q),
    .now_s  (in_sample),
    .frac   (blend_frac),
    .mode   (mode_eff),
    .mixed  (mixed)
  );

  decim_sat #(.EW(EW), .OUT_W(OUT_W)) u_sat (
    .val     (mixed),
    .clamped (sat_val)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)  last_q <= '0;
    else if (step) last_q <= in_sample;
  end

  always_comb begin
    vld_d  = vld_q;
    data_d = data_q;
    if (fire) begin
      vld_d  = 1'b1;
      data_d = sat_val;
    end else if (out_ready) begin
      vld_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
    end
  end

  assign out_valid  = vld_q;
  assign out_sample = data_q;
endmodule

// File: rtl/decim_rate_chk.sv
module decim_rate_chk #(
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [OUT_W-1:0] out_sample,
  input logic signed [10:0]      phase_off
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10
  src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R8
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_off >= -11'sd512));
endmodule

bind decim_rate decim_rate_chk #(.OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sample (out_sample),
  .phase_off  (phase_off)
);

// File: tb/decim_rate_tb.sv
module decim_rate_tb;
  localparam int IN_W    = 20;
  localparam int OUT_W   = 16;
  localparam int RATIO_W = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                    rst_n;
  logic                    mode_sel;
  logic [RATIO_W-1:0]      ratio;
  logic                    in_valid, in_ready;
  logic signed [IN_W-1:0]  in_sample;
  logic                    out_valid, out_ready;
  logic signed [OUT_W-1:0] out_sample;

  decim_rate #(.IN_W(IN_W), .OUT_W(OUT_W), .RATIO_W(RATIO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ratio(ratio),
    .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int unsigned rs = 32'h1badf00d;

  longint m_off, m_prev;
  int     m_cnt;
  bit     m_mode;
  longint expq[$];
  string  tagq[$];
  bit     stalled;
  longint held;

  function automatic int unsigned nxt_rnd();
    rs ^= rs << 13;
    rs ^= rs >> 17;
    rs ^= rs << 5;
    return rs;
  endfunction

  function automatic longint rnd_amp(longint amp);
    longint u;
    u = longint'(nxt_rnd());
    return (u % (2 * amp + 1)) - amp;
  endfunction

  function automatic longint sat_m(longint v);
    longint hi, lo;
    hi = (64'sd1 <<< (OUT_W - 1)) - 1;
    lo = -(64'sd1 <<< (OUT_W - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic m_accept(longint x, bit md, longint r, string tag);
    longint nx, e;
    if (m_cnt == 0) begin
      m_mode = md;
      nx     = m_off + r + (md ? 0 : 512);
      m_cnt  = int'(nx >>> 10);
      if (m_cnt == 0) m_cnt = 1;
      m_off  = md ? (nx & 1023) : ((nx & 1023) - 512);
    end
    m_cnt--;
    if (m_cnt == 0) begin
      e = m_mode ? (m_prev + ((m_off * (x - m_prev)) >>> 10)) : x;
      expq.push_back(sat_m(e));
      tagq.push_back(tag);
    end
    m_prev = x;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_sample = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_off = 0; m_prev = 0; m_cnt = 0; m_mode = 0;
    expq.delete(); tagq.delete(); stalled = 0;
    #1;
    chk(out_valid == 1'b0, "R1", out_valid, 0, "out_valid after reset");
    chk(in_ready == 1'b1, "R1", in_ready, 1, "in_ready after reset");
  endtask

  task automatic step(bit v, longint x, bit rdy, bit md, longint r, string tag);
    longint got, e;
    string  t;
    @(negedge clk);
    in_valid = v; in_sample = IN_W'(x); out_ready = rdy;
    mode_sel = md; ratio = RATIO_W'(r);
    #1;
    if (stalled) begin
      chk(out_valid == 1'b1, "R8", out_valid, 1, "valid held in stall");
      chk(longint'(out_sample) == held, "R8", longint'(out_sample), held, "data held in stall");
    end
    if (out_valid && out_ready) begin
      got = longint'(out_sample);
      if (expq.size() == 0) begin
        chk(0, tag, got, 0, "unexpected output");
      end else begin
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(got == e, t, got, e, "output sample");
      end
    end
    if (out_valid && !out_ready)
      chk(in_ready == 1'b0, "R8", in_ready, 0, "source blocked in stall");
    stalled = out_valid && !out_ready;
    held    = longint'(out_sample);
    if (v && in_ready) m_accept(x, md, r, tag);
  endtask

  task automatic run_block(bit md, longint r, int n, longint amp,
                           bit rnd_rdy, bit rnd_vld, bit vary, string tag);
    bit     cm, v, rd;
    longint cr;
    for (int i = 0; i < n; i++) begin
      cm = md; cr = r;
      if (vary) begin
        cm = ((i / 5) % 2) != 0 ? ~md : md;
        cr = r + longint'((i / 3) % 3) * 333;
      end
      v  = rnd_vld ? nxt_rnd()[3] : 1'b1;
      rd = rnd_rdy ? nxt_rnd()[5] : 1'b1;
      step(v, rnd_amp(amp), rd, cm, cr, tag);
    end
    for (int i = 0; i < 12; i++) step(1'b0, 0, 1'b1, md, r, tag);
    chk(expq.size() == 0, tag, expq.size(), 0, "outputs outstanding");
    chk(out_valid == 1'b0, tag, out_valid, 0, "idle after drain");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_sample = '0;
    mode_sel = 1'b0; ratio = '0;
    do_reset();
    // R2 R3 R4 R5: sweep of ratios in both modes
    for (int r = 1024; r <= 4200; r += 97) begin
      for (int md = 0; md < 2; md++) begin
        do_reset();
        run_block(md[0], r, 40, 3000, 1'b0, 1'b0, 1'b0, md != 0 ? "R5" : "R2");
      end
    end
    // R3: half-cycle ratio exercises negative remainders
    do_reset();
    run_block(1'b0, 1536, 60, 5000, 1'b0, 1'b0, 1'b0, "R3");
    // R4: blend with fractional ratio
    do_reset();
    run_block(1'b1, 2355, 80, 40000, 1'b0, 1'b0, 1'b0, "R4");
    // R6 and R1: first interval of one sample uses the cleared previous value
    do_reset();
    run_block(1'b1, 1100, 60, 20000, 1'b0, 1'b0, 1'b0, "R6");
    // R7: full-scale input saturates in both modes
    for (int md = 0; md < 2; md++) begin
      do_reset();
      run_block(md[0], 1500, 80, (64'sd1 <<< (IN_W - 1)) - 1, 1'b0, 1'b0, 1'b0, "R7");
    end
    // R8: output stalls, with drain and completion in the same cycle
    for (int md = 0; md < 2; md++) begin
      do_reset();
      run_block(md[0], 1090, 200, 30000, 1'b1, 1'b0, 1'b0, "R8");
    end
    // R10: gaps in the source, and a ratio below one
    do_reset();
    run_block(1'b1, 2800, 200, 30000, 1'b1, 1'b1, 1'b0, "R10");
    do_reset();
    run_block(1'b0, 700, 40, 30000, 1'b0, 1'b0, 1'b0, "R10");
    // R9: ratio and mode change inside intervals
    do_reset();
    run_block(1'b0, 2500, 300, 30000, 1'b1, 1'b1, 1'b1, "R9");
    do_reset();
    run_block(1'b1, 1300, 300, 30000, 1'b0, 1'b0, 1'b1, "R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule